// File: doc/BRIEF.md
# Serial Canonic Signed-Digit Recoder

This block rewrites a binary constant as a string of signed digits, each worth -1, 0 or +1, so that no two neighbouring digits are both nonzero. A constant in that form needs the fewest add or subtract terms when it is later turned into a shift-and-add product, which is why coefficient generators feed their words through it.

A one-cycle start pulse loads an input word and a mode bit. The mode bit selects whether the word is read as unsigned or as two's complement. The default engine then walks the word from the least significant bit upward, one position per clock, with a single carry bit of state. It raises a one-cycle completion flag when all WIDTH+1 digits are ready, and it holds them until the next accepted start. A parameter can instead select an engine that unrolls the same step for every position and registers the full result one clock after start.

Top module: `csd_recoder`

## Requirements
- R1: Each digit occupies two bits of `digits`. Digit i sits at bits [2i+1:2i]. Zero is coded 2'b00, +1 is 2'b01 and -1 is 2'b11, and the code 2'b10 never appears in a completed result.
- R2: In a completed result, no two adjacent digits are both nonzero.
- R3: The completed result has WIDTH+1 digits. The sum of digit i times 2^i equals the input word's value, read as unsigned when `is_signed` is 0 and as two's complement when `is_signed` is 1. The carry left after the top digit equals the sign extension bit.
- R4: The result is the unique nonadjacent form of the value, so its count of nonzero digits is the minimum possible.
- R5: Digits are produced from the least significant position upward using a carry state c. With c=0: a current bit of 0 gives 0 and keeps c=0; bits 1 then 1 above give -1 and set c=1; bit 1 with 0 above gives +1 and keeps c=0. With c=1: a current bit of 1 gives 0 and keeps c=1; bit 0 with 1 above gives -1 and keeps c=1; bit 0 with 0 above gives +1 and clears c. Above the MSB, the bit is 0 for unsigned input and the sign bit for signed input.
- R6: Serial engine: a start sampled while idle sets `busy` at that edge. `done` is high for exactly one cycle, WIDTH+1 clock edges after that edge, and `busy` drops at the same edge.
- R7: Serial engine: a start sampled while `busy` is high is ignored, together with its word and mode. The run in progress finishes on time with the first word's result.
- R8: Once a result completes, `digits` keeps its value until the next accepted start, whatever the other inputs do.
- R9: After reset, `busy` and `done` are 0 and `digits` is all zeros.
- R10: Parallel engine (PARALLEL=1): `done` is high in the cycle after each sampled start, and `digits` then holds the same result the serial engine gives for that word and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load request, sampled on the rising edge |
| is_signed | input | 1 | 1: word is two's complement; 0: unsigned |
| word_in | input | WIDTH | Binary constant to recode |
| busy | output | 1 | Serial recoding in progress (always 0 in the parallel engine) |
| done | output | 1 | One-cycle flag: `digits` holds a fresh result |
| digits | output | 2*(WIDTH+1) | Signed digits, two bits per digit, digit 0 in the low bits |

## Verification
In the serial engine, `busy` is due at the start edge and `done` is due WIDTH+1 edges after it. In the parallel engine, `done` is due one edge after start. The bench drives inputs on falling edges and counts falling edges from the start edge until `done` appears. It requires that count to equal the expected latency exactly, and it samples `digits` in that same half cycle. The flag must then be low one cycle later, and the digits must stay unchanged over the idle cycles that follow.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Two-bit signed digit code: bit 0 marks nonzero, bit 1 marks negative.
    typedef enum logic [1:0] {
        SD_ZERO = 2'b00,
        SD_POS  = 2'b01,
        SD_NEG  = 2'b11
    } sdigit_e;

endpackage

// File: rtl/csd_step.sv
// One recoding cell: carry state plus current and next bit in,
// signed digit and next carry state out.
module csd_step
    import csd_pkg::*;
(
    input  logic       carry_in,
    input  logic       bit_cur,
    input  logic       bit_nxt,
    output logic [1:0] dig,
    output logic       carry_out
);

    always_comb begin
        dig       = SD_ZERO;
        carry_out = 1'b0;
        unique case ({carry_in, bit_cur, bit_nxt})
            3'b000, 3'b001: begin dig = SD_ZERO; carry_out = 1'b0; end
            3'b010:         begin dig = SD_POS;  carry_out = 1'b0; end
            3'b011:         begin dig = SD_NEG;  carry_out = 1'b1; end
            3'b100:         begin dig = SD_POS;  carry_out = 1'b0; end
            3'b101:         begin dig = SD_NEG;  carry_out = 1'b1; end
            3'b110, 3'b111: begin dig = SD_ZERO; carry_out = 1'b1; end
            default:        begin dig = SD_ZERO; carry_out = 1'b0; end
        endcase
    end

endmodule

// File: rtl/csd_serial_engine.sv
// One digit per clock; operand and digit registers both shift right.
module csd_serial_engine #(
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_signed,
    input  logic [WIDTH-1:0]         word_in,
    output logic                     busy,
    output logic                     done,
    output logic [2*(WIDTH+1)-1:0]   digits
);

    localparam int ND = WIDTH + 1;
    localparam int DW = 2 * ND;
    localparam int CW = $clog2(ND + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          carry;
        logic          ext;
        logic [CW-1:0] cnt;
        logic [ND-1:0] bits;
        logic [DW-1:0] digits;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic [1:0] step_dig;
    logic       step_carry;
    logic       load_ext;

    csd_step u_step (
        .carry_in  (st_q.carry),
        .bit_cur   (st_q.bits[0]),
        .bit_nxt   (st_q.bits[1]),
        .dig       (step_dig),
        .carry_out (step_carry)
    );

    assign load_ext = is_signed & word_in[WIDTH-1];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.carry = 1'b0;
                st_d.cnt   = '0;
                st_d.ext   = load_ext;
                st_d.bits  = {load_ext, word_in};
            end
        end else begin
            st_d.digits = {step_dig, st_q.digits[DW-1:2]};
            st_d.carry  = step_carry;
            st_d.bits   = {st_q.ext, st_q.bits[ND-1:1]};
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(ND - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign digits = st_q.digits;

    // R6: completion flag lasts one cycle and only ends a run
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy));
    // R3: carry after the top position settles on the extension bit
    a_r3_carry_settles: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == CW'(ND - 1)) |-> (step_carry == st_q.ext));
    // R8: idle without start leaves the result untouched
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> $stable(st_q.digits));
    // R7: a start while busy does not restart the count
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != CW'(ND - 1)) |=> (st_q.busy && st_q.cnt != '0));

endmodule

// File: rtl/csd_parallel_engine.sv
// All positions recoded in one combinational ripple, result registered.
module csd_parallel_engine #(
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_signed,
    input  logic [WIDTH-1:0]         word_in,
    output logic                     done,
    output logic [2*(WIDTH+1)-1:0]   digits
);

    localparam int ND = WIDTH + 1;
    localparam int DW = 2 * ND;

    typedef struct packed {
        logic          done;
        logic [DW-1:0] digits;
    } par_state_t;

    par_state_t st_d, st_q;
    logic          ext;
    logic [ND:0]   ext_word;
    logic [ND:0]   carry_w;
    logic [DW-1:0] comb_digits;

    assign ext        = is_signed & word_in[WIDTH-1];
    assign ext_word   = {ext, ext, word_in};
    assign carry_w[0] = 1'b0;

    for (genvar g = 0; g < ND; g++) begin : g_cell
        csd_step u_step (
            .carry_in  (carry_w[g]),
            .bit_cur   (ext_word[g]),
            .bit_nxt   (ext_word[g+1]),
            .dig       (comb_digits[2*g +: 2]),
            .carry_out (carry_w[g+1])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) st_d.digits = comb_digits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done   = st_q.done;
    assign digits = st_q.digits;

    // R10: result flagged on the cycle after start
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.done);
    // R3: ripple carry out of the top cell equals the extension bit
    a_r3_par_carry: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (carry_w[ND] == ext));
    // R8: no start, no change of result
    a_r8_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(st_q.digits));

endmodule

// File: rtl/csd_recoder.sv
module csd_recoder #(
    parameter int WIDTH    = 16,
    parameter bit PARALLEL = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_signed,
    input  logic [WIDTH-1:0]         word_in,
    output logic                     busy,
    output logic                     done,
    output logic [2*(WIDTH+1)-1:0]   digits
);

    localparam int ND = WIDTH + 1;
    localparam int DW = 2 * ND;

    if (PARALLEL) begin : g_par
        csd_parallel_engine #(.WIDTH(WIDTH)) u_engine (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .is_signed (is_signed),
            .word_in   (word_in),
            .done      (done),
            .digits    (digits)
        );
        assign busy = 1'b0;
    end else begin : g_ser
        csd_serial_engine #(.WIDTH(WIDTH)) u_engine (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start),
            .is_signed (is_signed),
            .word_in   (word_in),
            .busy      (busy),
            .done      (done),
            .digits    (digits)
        );
    end

    function automatic logic bad_code(input logic [DW-1:0] v);
        logic r = 1'b0;
        for (int i = 0; i < ND; i++) if (v[2*i +: 2] == 2'b10) r = 1'b1;
        return r;
    endfunction

    function automatic logic adjacent_nonzero(input logic [DW-1:0] v);
        logic r = 1'b0;
        for (int i = 0; i < ND - 1; i++) if (v[2*i] && v[2*i+2]) r = 1'b1;
        return r;
    endfunction

    // R1: only the three legal digit codes in a completed result
    a_r1_digit_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bad_code(digits));
    // R2: nonadjacency of nonzero digits
    a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !adjacent_nonzero(digits));

endmodule

// File: tb/csd_recoder_bench.sv
module csd_recoder_bench;

    localparam int W  = 8;
    localparam int ND = W + 1;
    localparam int DW = 2 * ND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, p_start = 1'b0;
    logic          is_signed = 1'b0;
    logic [W-1:0]  word_in = '0;
    logic          busy, done, p_busy, p_done;
    logic [DW-1:0] digits, p_digits;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    csd_recoder #(.WIDTH(W), .PARALLEL(1'b0)) u_csd_recoder (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .word_in(word_in), .busy(busy), .done(done), .digits(digits));

    csd_recoder #(.WIDTH(W), .PARALLEL(1'b1)) u_csd_recoder_par (
        .clk(clk), .rst_n(rst_n), .start(p_start), .is_signed(is_signed),
        .word_in(word_in), .busy(p_busy), .done(p_done), .digits(p_digits));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Independent model: nonadjacent form by repeated reduction.
    function automatic logic [DW-1:0] naf_ref(input longint n);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < ND; i++) begin
            if (n[0]) begin
                if ((n & 3) == 1) begin r[2*i +: 2] = 2'b01; n = n - 1; end
                else              begin r[2*i +: 2] = 2'b11; n = n + 1; end
            end
            n = n >>> 1;
        end
        return r;
    endfunction

    function automatic longint dval(input logic [DW-1:0] v);
        longint s = 0;
        for (int i = 0; i < ND; i++) begin
            if (v[2*i +: 2] == 2'b01) s = s + (longint'(1) << i);
            if (v[2*i +: 2] == 2'b11) s = s - (longint'(1) << i);
        end
        return s;
    endfunction

    function automatic int nz_count(input logic [DW-1:0] v);
        int c = 0;
        for (int i = 0; i < ND; i++) if (v[2*i]) c++;
        return c;
    endfunction

    function automatic bit legal(input logic [DW-1:0] v);
        bit ok = 1'b1;
        for (int i = 0; i < ND; i++) if (v[2*i +: 2] == 2'b10) ok = 1'b0;
        for (int i = 0; i < ND - 1; i++) if (v[2*i] && v[2*i+2]) ok = 1'b0;
        return ok;
    endfunction

    function automatic longint wval(input logic [W-1:0] w, input logic s);
        return s ? longint'($signed(w)) : longint'(w);
    endfunction

    task automatic run_serial(input logic [W-1:0] w, input logic s, output int lat);
        @(negedge clk);
        word_in = w; is_signed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", longint'(busy), 1);
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic [DW-1:0] v, input logic [W-1:0] w, input logic s);
        logic [DW-1:0] e = naf_ref(wval(w, s));
        chk(v == e, "R4 canonic form", longint'(v), longint'(e));
        chk(dval(v) == wval(w, s), "R3 digit value", dval(v), wval(w, s));
        chk(legal(v), "R1 R2 code and adjacency", longint'(v), longint'(e));
        chk(nz_count(v) == nz_count(e), "R4 nonzero count", nz_count(v), nz_count(e));
    endtask

    task automatic t_reset;
        chk(busy == 1'b0 && done == 1'b0, "R9 flags after reset", {busy, done}, 0);
        chk(digits == '0, "R9 digits after reset", longint'(digits), 0);
        chk(p_done == 1'b0 && p_digits == '0, "R9 parallel after reset", longint'(p_digits), 0);
    endtask

    task automatic t_table_cases;
        int lat;
        run_serial(8'h07, 1'b0, lat);
        chk(digits == 18'h00043, "R5 seven is 8-1", longint'(digits), 18'h00043);
        run_serial(8'hFF, 1'b0, lat);
        chk(digits == 18'h10003, "R5 unsigned 255 uses top digit", longint'(digits), 18'h10003);
        run_serial(8'hFF, 1'b1, lat);
        chk(digits == 18'h00003, "R5 signed minus one", longint'(digits), 18'h00003);
        run_serial(8'h80, 1'b1, lat);
        chk(digits == 18'h0C000, "R5 signed minimum", longint'(digits), 18'h0C000);
        run_serial(8'h80, 1'b0, lat);
        chk(digits == 18'h04000, "R5 unsigned 128", longint'(digits), 18'h04000);
        run_serial(8'h55, 1'b0, lat);
        chk(digits == 18'h01111, "R5 alternating bits stay positive", longint'(digits), 18'h01111);
        run_serial(8'h00, 1'b1, lat);
        chk(digits == '0, "R5 zero word", longint'(digits), 0);
    endtask

    task automatic t_exhaustive_serial;
        int lat;
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < (1 << W); w++) begin
                run_serial(W'(w), s[0], lat);
                chk(lat == ND, "R6 latency", lat, ND);
                check_result(digits, W'(w), s[0]);
            end
        end
    endtask

    task automatic t_pulse_and_hold;
        int lat;
        logic [DW-1:0] held;
        run_serial(8'hB6, 1'b1, lat);
        held = digits;
        @(negedge clk);
        word_in = 8'h3C; is_signed = 1'b0;
        chk(done == 1'b0, "R6 done lasts one cycle", longint'(done), 0);
        chk(busy == 1'b0, "R6 busy clear after run", longint'(busy), 0);
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(digits == held, "R8 result held while idle", longint'(digits), longint'(held));
    endtask

    task automatic t_ignore_start;
        int lat;
        @(negedge clk);
        word_in = 8'h37; is_signed = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); lat++; end
        word_in = 8'hC9; is_signed = 1'b1; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        chk(lat == ND, "R7 run not restarted", lat, ND);
        chk(digits == naf_ref(wval(8'h37, 1'b0)), "R7 first word kept",
            longint'(digits), longint'(naf_ref(wval(8'h37, 1'b0))));
        @(negedge clk);
        chk(busy == 1'b0, "R7 no second run queued", longint'(busy), 0);
    endtask

    task automatic t_parallel;
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < (1 << W); w++) begin
                @(negedge clk);
                word_in = W'(w); is_signed = s[0]; p_start = 1'b1;
                @(negedge clk);
                p_start = 1'b0;
                chk(p_done == 1'b1, "R10 done one cycle after start", longint'(p_done), 1);
                chk(p_digits == naf_ref(wval(W'(w), s[0])), "R10 same result",
                    longint'(p_digits), longint'(naf_ref(wval(W'(w), s[0]))));
                @(negedge clk);
                chk(p_done == 1'b0, "R10 done drops", longint'(p_done), 0);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table_cases();
        t_exhaustive_serial();
        t_pulse_and_hold();
        t_ignore_start();
        t_parallel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule